// File: doc/BRIEF.md
# Descriptor Chain Fetch Unit

This unit sits between a DMA engine and an external memory that holds transfer descriptors. Each descriptor is four 32-bit words. When the engine asks for a chain, the unit reads the head descriptor from the memory and captures the four words. It shows them to the engine and waits until the engine reports that the current burst is complete. If the descriptor is not marked as the end of its chain, the unit then fetches the descriptor that the index field points to. The memory's read latency is not fixed, so a word is taken only when the memory raises its read-valid strobe.

The same memory is also reached by a register-bus slave. A slave read keeps its request and address asserted until the memory returns valid data. A slave write is a single-cycle strobe with no acknowledge from the memory. The engine has priority. A slave access that arrives during a four-word fetch waits until all four words have come back.

Top module: `bd_fetch_unit`

## Requirements
- R1: After reset, `ram_re`, `ram_we`, `desc_ready`, `desc_valid` and `reg_ack` are all low.
- R2: An engine fetch of descriptor index d drives `ram_re` for four consecutive cycles, with `ram_raddr` = {d, 2'd0}, {d, 2'd1}, {d, 2'd2} and {d, 2'd3} in that order. The memory word address is the index concatenated with the two-bit word number.
- R3: Returned words are captured only in cycles where `ram_rvalid` is high, in the order they were requested, for any memory latency.
- R4: One cycle after the fourth word is captured, `desc_ready` is high for exactly one cycle. `desc_valid` is high from that cycle until the engine's `burst_done`.
- R5: Word 0 appears on `desc_src`, word 1 on `desc_dst`, word 2 on `desc_len` and word 3 on `desc_ctrl`. `desc_last` is bit 31 of word 3, and bits 7:0 of word 3 give the next descriptor index.
- R6: If `burst_done` arrives while `desc_last` is low, the next descriptor is fetched. If it arrives while `desc_last` is high, `desc_valid` drops and no further reads are issued.
- R7: A slave read holds `ram_re` high with a stable `ram_raddr` until `ram_rvalid`. `reg_ack` rises in that same cycle, with `reg_rdata` equal to the returned word.
- R8: A slave write with no engine fetch in progress drives `ram_we` for one cycle with `reg_addr`/`reg_wdata`, and `reg_ack` is high in the same cycle.
- R9: While an engine fetch is outstanding, no slave access is granted. A slave request that arrives together with `fetch_start` also waits.
- R10: A `fetch_start` that arrives while a chain is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_start | input | 1 | Engine request to start a chain |
| fetch_head | input | 8 | Head descriptor index from the channel register |
| burst_done | input | 1 | Engine has finished the current descriptor's burst |
| desc_ready | output | 1 | One-cycle pulse: new descriptor captured |
| desc_valid | output | 1 | Descriptor words are being held for the engine |
| desc_src | output | 32 | Word 0, source address |
| desc_dst | output | 32 | Word 1, destination address |
| desc_len | output | 32 | Word 2, length and burst size |
| desc_ctrl | output | 32 | Word 3, flags and next index |
| desc_last | output | 1 | End-of-chain flag (word 3 bit 31) |
| reg_req | input | 1 | Slave access request |
| reg_we | input | 1 | Slave access is a write |
| reg_addr | input | 10 | Slave word address |
| reg_wdata | input | 32 | Slave write data |
| reg_ack | output | 1 | Slave access complete |
| reg_rdata | output | 32 | Slave read data |
| ram_re | output | 1 | Memory read request |
| ram_raddr | output | 10 | Memory read address |
| ram_rdata | input | 32 | Memory read data |
| ram_rvalid | input | 1 | Memory read data valid |
| ram_we | output | 1 | Memory write enable |
| ram_waddr | output | 10 | Memory write address |
| ram_wdata | output | 32 | Memory write data |

## Verification
Several properties are checked on every cycle:
- the consecutive addresses of an issue run;
- the single-cycle width of the ready pulse and the fact that it falls within the valid window;
- a stable held address during a slave read;
- an acknowledge on every write;
- no slave grant while a fetch is outstanding;
- the drop of `desc_valid` after the last descriptor.

Only the bench scenarios can show that the captured words match memory contents under different latencies. The same holds for chains being followed through the index field, including wrap-around at index 255, for an ignored `fetch_start` during an active chain, and for a slave request waiting for exactly four returned words.

// File: rtl/bd_fetch_pkg.sv
package bd_fetch_pkg;
  localparam int BD_WORD_W   = 32;
  localparam int BD_WORDS    = 4;
  localparam int BD_SEL_W    = $clog2(BD_WORDS);
  localparam int BD_MAX_DESC = 256;
  localparam int BD_IDX_W    = $clog2(BD_MAX_DESC);
  localparam int BD_AW       = BD_IDX_W + BD_SEL_W;
  localparam int BD_LAST_BIT = 31;

  typedef logic [BD_WORD_W-1:0] bd_word_t;
  typedef logic [BD_SEL_W-1:0]  bd_sel_t;
  typedef logic [BD_IDX_W-1:0]  bd_idx_t;
  typedef logic [BD_AW-1:0]     bd_addr_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_ARM, ENG_ISSUE, ENG_COLLECT, ENG_HOLD
  } eng_state_e;

  function automatic bd_addr_t word_addr(bd_idx_t idx, bd_sel_t sel);
    return {idx, sel};
  endfunction

  function automatic logic desc_is_last(bd_word_t ctrl);
    return ctrl[BD_LAST_BIT];
  endfunction

  function automatic bd_idx_t desc_next(bd_word_t ctrl);
    return ctrl[BD_IDX_W-1:0];
  endfunction
endpackage

// File: rtl/bd_fetch_seq.sv
module bd_fetch_seq
  import bd_fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_start,
  input  bd_idx_t    head,
  input  logic       burst_done,
  input  bd_word_t   ctrl_word,
  input  logic       slave_busy,
  input  logic       cap_done,
  output eng_state_e state,
  output bd_sel_t    issue_sel,
  output bd_idx_t    cur_idx,
  output logic       eng_claim,
  output logic       desc_ready
);
  localparam bd_sel_t LAST_SEL = bd_sel_t'(BD_WORDS - 1);

  logic chain_last;
  assign chain_last = desc_is_last(ctrl_word);

  // engine takes the memory this cycle (slave must not be granted)
  assign eng_claim = (state == ENG_IDLE && fetch_start) ||
                     (state == ENG_HOLD && burst_done && !chain_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      issue_sel  <= '0;
      cur_idx    <= '0;
      desc_ready <= 1'b0;
    end else begin
      desc_ready <= 1'b0;
      unique case (state)
        ENG_IDLE: if (fetch_start) begin
          cur_idx <= head;
          state   <= ENG_ARM;
        end
        ENG_ARM: if (!slave_busy) begin
          issue_sel <= '0;
          state     <= ENG_ISSUE;
        end
        ENG_ISSUE: begin
          issue_sel <= issue_sel + 1'b1;
          if (cap_done) begin
            state      <= ENG_HOLD;
            desc_ready <= 1'b1;
          end else if (issue_sel == LAST_SEL) begin
            state <= ENG_COLLECT;
          end
        end
        ENG_COLLECT: if (cap_done) begin
          state      <= ENG_HOLD;
          desc_ready <= 1'b1;
        end
        ENG_HOLD: if (burst_done) begin
          if (chain_last) begin
            state <= ENG_IDLE;
          end else begin
            cur_idx <= desc_next(ctrl_word);
            state   <= ENG_ARM;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bd_word_capture.sv
module bd_word_capture
  import bd_fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic active,
  input  logic rvalid,
  input  bd_word_t rdata,
  output logic [BD_WORDS-1:0][BD_WORD_W-1:0] words,
  output logic cap_done
);
  localparam bd_sel_t LAST_SEL = bd_sel_t'(BD_WORDS - 1);

  bd_sel_t cnt;
  logic    take;

  assign take     = active && rvalid;
  assign cap_done = take && (cnt == LAST_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (take)   cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < BD_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             words[g] <= '0;
      else if (take && cnt == bd_sel_t'(g))   words[g] <= rdata;
    end
  end
endmodule

// File: rtl/bd_slave_port.sv
module bd_slave_port
  import bd_fetch_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req,
  input  logic     we,
  input  bd_addr_t addr,
  input  logic     may_grant,
  input  logic     rvalid,
  output logic     grant,
  output logic     wr_en,
  output logic     busy,
  output bd_addr_t hold_addr,
  output logic     ack
);
  assign grant = req && !busy && may_grant;
  assign wr_en = grant && we;
  assign ack   = wr_en || (busy && rvalid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      hold_addr <= '0;
    end else if (grant && !we) begin
      busy      <= 1'b1;
      hold_addr <= addr;
    end else if (busy && rvalid) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/bd_fetch_unit.sv
module bd_fetch_unit
  import bd_fetch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_start,
  input  logic [BD_IDX_W-1:0]  fetch_head,
  input  logic                 burst_done,
  output logic                 desc_ready,
  output logic                 desc_valid,
  output logic [BD_WORD_W-1:0] desc_src,
  output logic [BD_WORD_W-1:0] desc_dst,
  output logic [BD_WORD_W-1:0] desc_len,
  output logic [BD_WORD_W-1:0] desc_ctrl,
  output logic                 desc_last,
  input  logic                 reg_req,
  input  logic                 reg_we,
  input  logic [BD_AW-1:0]     reg_addr,
  input  logic [BD_WORD_W-1:0] reg_wdata,
  output logic                 reg_ack,
  output logic [BD_WORD_W-1:0] reg_rdata,
  output logic                 ram_re,
  output logic [BD_AW-1:0]     ram_raddr,
  input  logic [BD_WORD_W-1:0] ram_rdata,
  input  logic                 ram_rvalid,
  output logic                 ram_we,
  output logic [BD_AW-1:0]     ram_waddr,
  output logic [BD_WORD_W-1:0] ram_wdata
);
  eng_state_e eng_state;
  bd_sel_t    issue_sel;
  bd_idx_t    cur_idx;
  logic       eng_claim, cap_done, slv_busy, slv_grant, slv_wr, issue_active;
  logic       eng_fetching, eng_arm;
  bd_addr_t   slv_addr;
  logic [BD_WORDS-1:0][BD_WORD_W-1:0] words;

  // named internal events, also watched by the checker
  assign issue_active = (eng_state == ENG_ISSUE);
  assign eng_fetching = issue_active || (eng_state == ENG_COLLECT);
  assign eng_arm      = (eng_state == ENG_ARM);

  bd_fetch_seq u_seq (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .head(fetch_head),
    .burst_done(burst_done), .ctrl_word(words[BD_WORDS-1]),
    .slave_busy(slv_busy), .cap_done(cap_done), .state(eng_state),
    .issue_sel(issue_sel), .cur_idx(cur_idx), .eng_claim(eng_claim),
    .desc_ready(desc_ready)
  );

  bd_word_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clear(eng_arm), .active(eng_fetching),
    .rvalid(ram_rvalid), .rdata(ram_rdata), .words(words), .cap_done(cap_done)
  );

  bd_slave_port u_slv (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
    .may_grant((eng_state == ENG_IDLE || eng_state == ENG_HOLD) && !eng_claim),
    .rvalid(ram_rvalid), .grant(slv_grant), .wr_en(slv_wr), .busy(slv_busy),
    .hold_addr(slv_addr), .ack(reg_ack)
  );

  assign ram_re    = issue_active || slv_busy;
  assign ram_raddr = issue_active ? word_addr(cur_idx, issue_sel) : slv_addr;
  assign ram_we    = slv_wr;
  assign ram_waddr = reg_addr;
  assign ram_wdata = reg_wdata;
  assign reg_rdata = ram_rdata;

  assign desc_valid = (eng_state == ENG_HOLD);
  assign desc_src   = words[0];
  assign desc_dst   = words[1];
  assign desc_len   = words[2];
  assign desc_ctrl  = words[3];
  assign desc_last  = desc_is_last(words[3]);
endmodule

// File: rtl/bd_fetch_chk.sv
module bd_fetch_chk
  import bd_fetch_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ram_re,
  input bd_addr_t ram_raddr,
  input logic     ram_rvalid,
  input logic     ram_we,
  input logic     reg_ack,
  input logic     desc_ready,
  input logic     desc_valid,
  input logic     desc_last,
  input logic     burst_done,
  input logic     issue_active,
  input bd_sel_t  issue_sel,
  input logic     slv_busy,
  input logic     eng_fetching
);
  // R2
  issue_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_active && issue_sel != bd_sel_t'(BD_WORDS - 1)) |=>
      (ram_re && ram_raddr == $past(ram_raddr) + 1'b1));

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |=> !desc_ready);

  // R4
  ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> desc_valid);

  // R6
  last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && burst_done && desc_last) |=> !desc_valid);

  // R7
  slave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_busy && !ram_rvalid) |=> (ram_re && $stable(ram_raddr)));

  // R8
  write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> reg_ack);

  // R9
  fetch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fetching |-> (!ram_we && !reg_ack));
endmodule

bind bd_fetch_unit bd_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ram_re(ram_re), .ram_raddr(ram_raddr),
  .ram_rvalid(ram_rvalid), .ram_we(ram_we), .reg_ack(reg_ack),
  .desc_ready(desc_ready), .desc_valid(desc_valid), .desc_last(desc_last),
  .burst_done(burst_done), .issue_active(issue_active), .issue_sel(issue_sel),
  .slv_busy(slv_busy), .eng_fetching(eng_fetching)
);

// File: tb/bd_fetch_unit_test.sv
module bd_fetch_unit_test;
  import bd_fetch_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 100000;
  localparam int NVEC       = 5;
  // head index, chain length, memory latency
  localparam int VECS [NVEC][3] = '{
    '{3, 1, 1}, '{17, 3, 2}, '{250, 3, 6}, '{100, 2, 3}, '{0, 2, 7}
  };

  logic clk = 0, rst_n = 0;
  logic fetch_start = 0, burst_done = 0, reg_req = 0, reg_we = 0;
  logic [BD_IDX_W-1:0] fetch_head = '0;
  logic [BD_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic desc_ready, desc_valid, desc_last, reg_ack, ram_re, ram_we, ram_rvalid;
  logic [31:0] desc_src, desc_dst, desc_len, desc_ctrl, reg_rdata, ram_rdata, ram_wdata;
  logic [BD_AW-1:0] ram_raddr, ram_waddr;

  int n_checks = 0, n_fail = 0, lat = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bd_fetch_unit uut (.*);

  // memory model: in-order responses after lat cycles; a held request answers once
  logic [31:0] mem [1024];
  logic pv [8];
  logic [BD_AW-1:0] pa [8];
  logic prev_re;
  logic [BD_AW-1:0] prev_addr;

  function automatic logic [31:0] pattern(int a);
    return 32'hC0DE_0000 ^ (a * 32'h0001_0003);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 1024; a++) mem[a] <= pattern(a);
      for (int i = 0; i < 8; i++) begin pv[i] <= 1'b0; pa[i] <= '0; end
      prev_re <= 1'b0; prev_addr <= '0;
    end else begin
      if (ram_we) mem[ram_waddr] <= ram_wdata;
      for (int i = 0; i < 7; i++) begin pv[i] <= pv[i+1]; pa[i] <= pa[i+1]; end
      pv[7] <= 1'b0;
      if (ram_re && !(prev_re && ram_raddr == prev_addr)) begin
        pv[lat-1] <= 1'b1; pa[lat-1] <= ram_raddr;
      end
      prev_re <= ram_re; prev_addr <= ram_raddr;
    end
  end
  assign ram_rvalid = pv[0];
  assign ram_rdata  = mem[pa[0]];

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic slave_write(input logic [BD_AW-1:0] a, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d; #1;
    chk("R8 write ack immediate", {29'd0, reg_ack, ram_we, 1'b0}, {29'd0, 1'b1, 1'b1, 1'b0});
    chk("R8 write addr", 32'(ram_waddr), 32'(a));
    chk("R8 write data", ram_wdata, d);
    @(negedge clk); reg_req = 0; reg_we = 0; #1;
  endtask

  task automatic pulse_fetch(input int head);
    fetch_start = 1; fetch_head = BD_IDX_W'(head);
    @(negedge clk); fetch_start = 0; #1;
  endtask

  task automatic pulse_done();
    burst_done = 1; @(negedge clk); burst_done = 0; #1;
  endtask

  task automatic wait_ready(input string tag);
    int g = 0;
    while (!desc_ready && g < 60) begin step(); g++; end
    chk(tag, 32'(desc_ready), 32'd1);
  endtask

  task automatic run_chain(input int head, input int n, input int l);
    int d = head;
    lat = l;
    for (int k = 0; k < n; k++) begin
      int nx = (d + 5) % 256;
      slave_write({d[7:0], 2'd3}, (k == n-1) ? 32'h8000_0000 : 32'(nx));
      d = nx;
    end
    pulse_fetch(head);
    d = head;
    for (int k = 0; k < n; k++) begin
      int g = 0;
      while (!ram_re && g < 30) begin step(); g++; end
      for (int w = 0; w < 4; w++) begin
        if (w > 0) step();
        chk("R2 issue address", ram_re ? 32'(ram_raddr) : 32'hFFFF_FFFF, 32'({d[7:0], 2'(w)}));
      end
      wait_ready("R4 ready pulse seen");
      chk("R5 R3 src word", desc_src, mem[{d[7:0], 2'd0}]);
      chk("R5 R3 dst word", desc_dst, mem[{d[7:0], 2'd1}]);
      chk("R5 R3 len word", desc_len, mem[{d[7:0], 2'd2}]);
      chk("R5 R3 ctrl word", desc_ctrl, mem[{d[7:0], 2'd3}]);
      chk("R5 last flag", 32'(desc_last), 32'(k == n-1));
      step();
      chk("R4 one-cycle ready, valid held", {30'd0, desc_ready, desc_valid}, 32'd1);
      pulse_done();
      d = (d + 5) % 256;
    end
    begin
      int seen = 0;
      for (int i = 0; i < 4; i++) begin if (ram_re || desc_valid) seen++; step(); end
      chk("R6 chain stops after last", 32'(seen), 32'd0);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset outputs", {27'd0, ram_re, ram_we, desc_ready, desc_valid, reg_ack}, 32'd0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 idle after release", {27'd0, ram_re, ram_we, desc_ready, desc_valid, reg_ack}, 32'd0);

    for (int v = 0; v < NVEC; v++) run_chain(VECS[v][0], VECS[v][1], VECS[v][2]);

    // R7 slave read with long latency holds its request
    lat = 4;
    begin
      int g = 0, bad = 0;
      reg_req = 1; reg_we = 0; reg_addr = 10'h123; step();
      while (!reg_ack && g < 30) begin
        if (!ram_re || ram_raddr != 10'h123) bad++;
        step(); g++;
      end
      chk("R7 held request", 32'(bad), 32'd0);
      chk("R7 read ack", 32'(reg_ack), 32'd1);
      chk("R7 read data", reg_rdata, mem[10'h123]);
      @(negedge clk); reg_req = 0; #1;
    end

    // R9 slave write during an engine fetch waits for all four words
    lat = 5;
    slave_write({8'd40, 2'd3}, 32'h8000_0000);
    pulse_fetch(40);
    begin
      int g = 0, vc = 0;
      while (!ram_re && g < 30) begin step(); g++; end
      reg_req = 1; reg_we = 1; reg_addr = 10'h3F0; reg_wdata = 32'h1234_5678; #1;
      g = 0;
      while (!reg_ack && g < 60) begin
        if (ram_rvalid) vc++;
        step(); g++;
      end
      chk("R9 write waited for four words", 32'(vc), 32'd4);
      @(negedge clk); reg_req = 0; reg_we = 0; #1;
      chk("R8 late write landed", mem[10'h3F0], 32'h1234_5678);
      pulse_done();
    end

    // R9 simultaneous fetch_start and slave read: engine first
    lat = 3;
    begin
      int g = 0, vc = 0;
      fetch_start = 1; fetch_head = 8'd40;
      reg_req = 1; reg_we = 0; reg_addr = 10'h155;
      @(negedge clk); fetch_start = 0; #1;
      while (!reg_ack && g < 60) begin
        if (ram_rvalid) vc++;
        step(); g++;
      end
      chk("R9 read waited for fetch", 32'(vc), 32'd4);
      chk("R9 read data after fetch", reg_rdata, mem[10'h155]);
      @(negedge clk); reg_req = 0; #1;
      pulse_done();
    end

    // R10 fetch_start during an active chain is ignored
    lat = 2;
    slave_write({8'd60, 2'd3}, 32'h8000_0000);
    pulse_fetch(60);
    wait_ready("R10 setup ready");
    step();
    begin
      int seen = 0;
      pulse_fetch(70);
      for (int i = 0; i < 3; i++) begin if (ram_re) seen++; step(); end
      chk("R10 descriptor unchanged", desc_ctrl, 32'h8000_0000);
      pulse_done();
      for (int i = 0; i < 8; i++) begin if (ram_re || desc_valid) seen++; step(); end
      chk("R10 ignored start issued no reads", 32'(seen), 32'd0);
    end

    finish_run();
  end
endmodule